// File: doc/BRIEF.md
# Two-Wire Device Programming Host Sequencer

This block is the host end of a two-wire serial programming link to a flash-based target. It drives a programming clock, a bidirectional data line with a separate drive enable, and a mode-enable line that holds the target in programming mode. After reset it performs the mode-entry handshake. Clock and data stay low while the mode-enable line rises, and they stay low for a guard period after it.

A local client then issues requests over a valid/ready handshake. Four kinds of request are supported. The first sends a 6-bit command alone. The second sends a command followed by a 14-bit word. The third sends a command and then reads a 14-bit word back from the target. The fourth runs one of two built-in bulk-erase recipes, one for unprotected and one for protected targets.

Every timing window is a parameter counted in system-clock cycles: clock half-period, inter-frame gap, programming time, erase time, and the mode-entry lead and guard times. Each request ends with a one-cycle done pulse, and the pulse arrives only after the last frame's trailing wait has run out.

Top module: `prog_link_host`

## Requirements
- R1: After reset, `mode_en`, `pgm_clk`, `pgm_dat_o` and `req_ready` are low and `pgm_dat_oe` is high. `mode_en` rises no sooner than ENTRY_PRE_CYC cycles after reset. `req_ready` stays low and `pgm_clk` stays low for at least ENTRY_POST_CYC cycles after that rise.
- R2: A command frame is exactly 6 clock pulses. Bit i of `req_cmd` is on `pgm_dat_o` at the i-th falling edge, so bit 0 goes first. `pgm_dat_oe` is high for the whole frame.
- R3: A write request sends its command frame and then a 16-pulse data frame. Pulse 0 carries 0, pulses 1 to 14 carry `req_word` bits 0 to 13, and pulse 15 carries 0.
- R4: Between the last falling edge of one frame and the first rising edge of the next, `pgm_clk` stays low for at least GAP_CYC cycles. This applies between a command and its data frame and between separate frames.
- R5: A read request sends its command frame and then 16 clock pulses with `pgm_dat_oe` low throughout. `pgm_dat_i` is sampled at the end of each high phase. Pulses 1 to 14 give `rd_word` bits 0 to 13. `rd_word` holds the result from the done pulse until the next read.
- R6: Each high phase of `pgm_clk` lasts exactly HALF_CYC cycles. Each low phase within a frame lasts exactly HALF_CYC cycles. `pgm_dat_o` changes only together with a rising edge, so it is stable across every falling edge.
- R7: After a command whose low four bits are 4'b1000 (a programming start), the next rising edge is at least PROG_CYC cycles after that frame's last falling edge. Inside an erase recipe the minimum is ERASE_CYC instead.
- R8: Request kind 3 runs the unprotected erase recipe. It loads program data with 0x3FFF (command 6'b000010). It then sends setup-1 (6'b000001), setup-2 (6'b000111) and start (6'b001000), waits ERASE_CYC, and sends setup-1 and setup-2 again.
- R9: Request kind 4 runs the protected erase recipe. It loads configuration with 0x3FFF (command 6'b000000), then sends seven address increments (6'b000110). After that it runs the same setup, start, wait and setup steps as R8.
- R10: `req_ready` is high only when the block is idle with the clock low and the line driven. A request is taken on `req_valid && req_ready` with kinds 0 = command, 1 = write, 2 = read, 3 and 4 = erase. Each request gives exactly one one-cycle `done` pulse, after its trailing wait.
- R11: Once `mode_en` has risen it stays high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Sequencer idle and able to take a request |
| req_kind | input | 3 | 0 command, 1 write, 2 read, 3 erase, 4 protected erase |
| req_cmd | input | 6 | Command code for kinds 0 to 2 |
| req_word | input | 14 | Word to send for kind 1 |
| done | output | 1 | One-cycle completion pulse |
| rd_word | output | 14 | Word returned by the latest read |
| mode_en | output | 1 | Programming-mode enable toward the target |
| pgm_clk | output | 1 | Programming clock |
| pgm_dat_o | output | 1 | Data driven toward the target |
| pgm_dat_oe | output | 1 | High while the host drives the data line |
| pgm_dat_i | input | 1 | Data returned by the target |

## Verification
The hardest conditions to reach are the long waits. One is the erase wait after a start command that the protected recipe issues twelve steps into its run. The other is the stand-alone programming wait, which the checks must tell apart from the ordinary gap. The bench shortens all timing parameters so that both recipes and the stand-alone start commands fit in a short run. A pin-level monitor rebuilds every frame and measures the idle time before it. It compares each frame against a queue of expected frames that carries the minimum gap each one must honour. The monitor also acts as the target for reads, placing a chosen word on the returned line rising edge by rising edge.

// File: rtl/prog_link_pkg.sv
package prog_link_pkg;

    localparam int CMD_W   = 6;
    localparam int WORD_W  = 14;
    localparam int FRAME_W = 16;
    localparam int STEP_W  = 4;

    typedef enum logic [2:0] {
        RK_CMD        = 3'd0,
        RK_WRITE      = 3'd1,
        RK_READ       = 3'd2,
        RK_ERASE_MAIN = 3'd3,
        RK_ERASE_PROT = 3'd4
    } req_kind_e;

    typedef enum logic [3:0] {
        ST_BOOT, ST_PRE, ST_POST, ST_IDLE, ST_LAUNCH,
        ST_CMD, ST_GAP, ST_DATA, ST_WAIT, ST_DONE
    } seq_state_e;

    localparam logic [CMD_W-1:0] OP_LOAD_CFG = 6'b000000;
    localparam logic [CMD_W-1:0] OP_LOAD_PGM = 6'b000010;
    localparam logic [CMD_W-1:0] OP_INC_ADDR = 6'b000110;
    localparam logic [CMD_W-1:0] OP_SETUP1   = 6'b000001;
    localparam logic [CMD_W-1:0] OP_SETUP2   = 6'b000111;
    localparam logic [CMD_W-1:0] OP_BEGIN    = 6'b001000;

    typedef struct packed {
        logic [CMD_W-1:0]  op;
        logic              has_word;
        logic              is_read;
        logic [WORD_W-1:0] word;
    } step_t;

    function automatic int max_of(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    // programming start commands share low nibble 1000
    function automatic logic is_prog_op(input logic [CMD_W-1:0] op);
        return op[3:0] == 4'b1000;
    endfunction

    function automatic logic [FRAME_W-1:0] frame_bits(input logic [WORD_W-1:0] w);
        return {1'b0, w, 1'b0};
    endfunction

    function automatic logic [STEP_W-1:0] erase_last(input logic prot);
        return prot ? 4'd12 : 4'd5;
    endfunction

    // step idx of an erase recipe; the protected one has 7 extra address steps
    function automatic step_t erase_step(input logic prot, input logic [STEP_W-1:0] idx);
        step_t s;
        logic [STEP_W-1:0] k;
        s.op       = OP_SETUP1;
        s.has_word = 1'b0;
        s.is_read  = 1'b0;
        s.word     = '1;
        k = prot ? (idx - 4'd7) : idx;
        if (idx == 4'd0) begin
            s.op       = prot ? OP_LOAD_CFG : OP_LOAD_PGM;
            s.has_word = 1'b1;
        end else if (prot && idx <= 4'd7) begin
            s.op = OP_INC_ADDR;
        end else begin
            case (k)
                4'd1:    s.op = OP_SETUP1;
                4'd2:    s.op = OP_SETUP2;
                4'd3:    s.op = OP_BEGIN;
                4'd4:    s.op = OP_SETUP1;
                default: s.op = OP_SETUP2;
            endcase
        end
        return s;
    endfunction

endpackage

// File: rtl/prog_link_timer.sv
module prog_link_timer #(
    parameter int TW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [TW-1:0] load_val,
    output logic          expired
);
    logic [TW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign expired = (cnt == '0);
endmodule

// File: rtl/prog_link_shifter.sv
module prog_link_shifter
    import prog_link_pkg::*;
#(
    parameter int HALF_CYC = 5
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               start,
    input  logic               rd_mode,
    input  logic [4:0]         nbits,
    input  logic [FRAME_W-1:0] tx,
    input  logic               dat_i,
    output logic               pclk,
    output logic               pdat,
    output logic               poe,
    output logic               fin,
    output logic [WORD_W-1:0]  rx
);
    localparam int HW = $clog2(HALF_CYC) + 1;
    localparam logic [HW-1:0] HLOAD = HW'(HALF_CYC - 1);

    logic               active;
    logic               hi_ph;
    logic [HW-1:0]      hcnt;
    logic [4:0]         idx;
    logic [4:0]         nbits_q;
    logic [FRAME_W-1:0] sh;
    logic               rdm;
    logic               ph_end;
    logic [3:0]         rpos;
    logic [3:0]         npos;

    assign ph_end = (hcnt == '0);
    assign rpos   = idx[3:0] - 4'd1;
    assign npos   = idx[3:0] + 4'd1;
    assign fin    = active && !hi_ph && ph_end && (idx == nbits_q - 5'd1);

    always_ff @(posedge clk) begin
        if (rst) begin
            active  <= 1'b0;
            hi_ph   <= 1'b0;
            hcnt    <= '0;
            idx     <= '0;
            nbits_q <= '0;
            sh      <= '0;
            rdm     <= 1'b0;
            pclk    <= 1'b0;
            pdat    <= 1'b0;
            poe     <= 1'b1;
            rx      <= '0;
        end else if (start && !active) begin
            active  <= 1'b1;
            hi_ph   <= 1'b1;
            hcnt    <= HLOAD;
            idx     <= '0;
            nbits_q <= nbits;
            sh      <= tx;
            rdm     <= rd_mode;
            pclk    <= 1'b1;
            pdat    <= rd_mode ? 1'b0 : tx[0];
            poe     <= !rd_mode;
        end else if (active) begin
            if (!ph_end) begin
                hcnt <= hcnt - 1'b1;
            end else if (hi_ph) begin
                // end of high phase: sample returned bit, then drop the clock
                if (rdm && idx >= 5'd1 && idx <= 5'd14)
                    rx[rpos] <= dat_i;
                pclk  <= 1'b0;
                hi_ph <= 1'b0;
                hcnt  <= HLOAD;
            end else if (fin) begin
                active <= 1'b0;
                pdat   <= 1'b0;
                poe    <= 1'b1;
            end else begin
                idx   <= idx + 5'd1;
                hi_ph <= 1'b1;
                pclk  <= 1'b1;
                hcnt  <= HLOAD;
                pdat  <= rdm ? 1'b0 : sh[npos];
            end
        end
    end
endmodule

// File: rtl/prog_link_seq.sv
module prog_link_seq
    import prog_link_pkg::*;
#(
    parameter int GAP_CYC   = 50,
    parameter int PROG_CYC  = 100000,
    parameter int ERASE_CYC = 400000,
    parameter int PRE_CYC   = 5,
    parameter int POST_CYC  = 250,
    parameter int TW        = 19
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               req_valid,
    input  logic [2:0]         req_kind,
    input  logic [CMD_W-1:0]   req_cmd,
    input  logic [WORD_W-1:0]  req_word,
    output logic               req_ready,
    output logic               done,
    output logic               mode_en,
    output logic               sh_start,
    output logic               sh_rd,
    output logic [4:0]         sh_nbits,
    output logic [FRAME_W-1:0] sh_tx,
    input  logic               sh_fin,
    output logic               tm_load,
    output logic [TW-1:0]      tm_val,
    input  logic               tm_exp
);
    localparam logic [TW-1:0] GAP_V   = TW'(GAP_CYC);
    localparam logic [TW-1:0] PROG_V  = TW'(PROG_CYC);
    localparam logic [TW-1:0] ERASE_V = TW'(ERASE_CYC);
    localparam logic [TW-1:0] PRE_V   = TW'(PRE_CYC);
    localparam logic [TW-1:0] POST_V  = TW'(POST_CYC);

    seq_state_e        state;
    step_t             cur;
    logic              in_macro;
    logic              prot;
    logic [STEP_W-1:0] idx;
    logic [TW-1:0]     wait_v;
    req_kind_e         kind;
    logic              kind_prot;

    assign kind      = req_kind_e'(req_kind);
    assign kind_prot = (kind == RK_ERASE_PROT);
    assign wait_v    = is_prog_op(cur.op) ? (in_macro ? ERASE_V : PROG_V) : GAP_V;

    assign req_ready = (state == ST_IDLE);
    assign done      = (state == ST_DONE);
    assign sh_start  = (state == ST_LAUNCH) || (state == ST_GAP && tm_exp);
    assign sh_rd     = (state == ST_GAP) && cur.is_read;
    assign sh_nbits  = (state == ST_GAP) ? 5'd16 : 5'd6;
    assign sh_tx     = (state == ST_GAP) ? frame_bits(cur.word)
                                         : {{(FRAME_W-CMD_W){1'b0}}, cur.op};

    always_comb begin
        tm_load = 1'b0;
        tm_val  = GAP_V;
        case (state)
            ST_BOOT: begin tm_load = 1'b1; tm_val = PRE_V; end
            ST_PRE:  if (tm_exp) begin tm_load = 1'b1; tm_val = POST_V; end
            ST_CMD:  if (sh_fin) begin
                         tm_load = 1'b1;
                         tm_val  = cur.has_word ? GAP_V : wait_v;
                     end
            ST_DATA: if (sh_fin) begin tm_load = 1'b1; tm_val = wait_v; end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_BOOT;
            mode_en  <= 1'b0;
            cur      <= '0;
            in_macro <= 1'b0;
            prot     <= 1'b0;
            idx      <= '0;
        end else begin
            case (state)
                ST_BOOT:   state <= ST_PRE;
                ST_PRE:    if (tm_exp) begin
                               mode_en <= 1'b1;
                               state   <= ST_POST;
                           end
                ST_POST:   if (tm_exp) state <= ST_IDLE;
                ST_IDLE:   if (req_valid) begin
                               if (kind == RK_ERASE_MAIN || kind_prot) begin
                                   in_macro <= 1'b1;
                                   prot     <= kind_prot;
                                   idx      <= '0;
                                   cur      <= erase_step(kind_prot, '0);
                               end else begin
                                   in_macro     <= 1'b0;
                                   cur.op       <= req_cmd;
                                   cur.has_word <= (kind == RK_WRITE) || (kind == RK_READ);
                                   cur.is_read  <= (kind == RK_READ);
                                   cur.word     <= req_word;
                               end
                               state <= ST_LAUNCH;
                           end
                ST_LAUNCH: state <= ST_CMD;
                ST_CMD:    if (sh_fin) state <= cur.has_word ? ST_GAP : ST_WAIT;
                ST_GAP:    if (tm_exp) state <= ST_DATA;
                ST_DATA:   if (sh_fin) state <= ST_WAIT;
                ST_WAIT:   if (tm_exp) begin
                               if (in_macro && idx != erase_last(prot)) begin
                                   idx   <= idx + 4'd1;
                                   cur   <= erase_step(prot, idx + 4'd1);
                                   state <= ST_LAUNCH;
                               end else begin
                                   state <= ST_DONE;
                               end
                           end
                ST_DONE:   state <= ST_IDLE;
                default:   state <= ST_BOOT;
            endcase
        end
    end
endmodule

// File: rtl/prog_link_host.sv
module prog_link_host
    import prog_link_pkg::*;
#(
    parameter int HALF_CYC       = 5,
    parameter int GAP_CYC        = 50,
    parameter int PROG_CYC       = 100000,
    parameter int ERASE_CYC      = 400000,
    parameter int ENTRY_PRE_CYC  = 5,
    parameter int ENTRY_POST_CYC = 250
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        req_valid,
    output logic        req_ready,
    input  logic [2:0]  req_kind,
    input  logic [5:0]  req_cmd,
    input  logic [13:0] req_word,
    output logic        done,
    output logic [13:0] rd_word,
    output logic        mode_en,
    output logic        pgm_clk,
    output logic        pgm_dat_o,
    output logic        pgm_dat_oe,
    input  logic        pgm_dat_i
);
    localparam int MAXC = max_of(max_of(max_of(GAP_CYC, PROG_CYC), max_of(ERASE_CYC, ENTRY_PRE_CYC)),
                                 ENTRY_POST_CYC);
    localparam int TW   = $clog2(MAXC + 1) + 1;

    logic               sh_start;
    logic               sh_rd;
    logic [4:0]         sh_nbits;
    logic [FRAME_W-1:0] sh_tx;
    logic               sh_fin;
    logic               tm_load;
    logic [TW-1:0]      tm_val;
    logic               tm_exp;

    prog_link_seq #(
        .GAP_CYC(GAP_CYC), .PROG_CYC(PROG_CYC), .ERASE_CYC(ERASE_CYC),
        .PRE_CYC(ENTRY_PRE_CYC), .POST_CYC(ENTRY_POST_CYC), .TW(TW)
    ) u_seq (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_kind(req_kind), .req_cmd(req_cmd), .req_word(req_word),
        .req_ready(req_ready), .done(done), .mode_en(mode_en),
        .sh_start(sh_start), .sh_rd(sh_rd), .sh_nbits(sh_nbits), .sh_tx(sh_tx),
        .sh_fin(sh_fin), .tm_load(tm_load), .tm_val(tm_val), .tm_exp(tm_exp)
    );

    prog_link_shifter #(.HALF_CYC(HALF_CYC)) u_shift (
        .clk(clk), .rst(rst), .start(sh_start), .rd_mode(sh_rd), .nbits(sh_nbits),
        .tx(sh_tx), .dat_i(pgm_dat_i), .pclk(pgm_clk), .pdat(pgm_dat_o),
        .poe(pgm_dat_oe), .fin(sh_fin), .rx(rd_word)
    );

    prog_link_timer #(.TW(TW)) u_tmr (
        .clk(clk), .rst(rst), .load(tm_load), .load_val(tm_val), .expired(tm_exp)
    );
endmodule

// File: rtl/prog_link_host_chk.sv
module prog_link_host_chk #(
    parameter int HALF_CYC = 5,
    parameter int GAP_CYC  = 50
) (
    input logic clk,
    input logic rst,
    input logic pgm_clk,
    input logic pgm_dat_o,
    input logic pgm_dat_oe,
    input logic mode_en,
    input logic req_ready,
    input logic done
);
    localparam int CW = $clog2(HALF_CYC + GAP_CYC + 2) + 1;
    localparam logic [CW-1:0] CMAX = '1;

    logic [CW-1:0] lo_cnt;
    logic [CW-1:0] hi_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            lo_cnt <= '0;
            hi_cnt <= '0;
        end else begin
            lo_cnt <= pgm_clk ? '0 : ((lo_cnt == CMAX) ? lo_cnt : lo_cnt + 1'b1);
            hi_cnt <= !pgm_clk ? '0 : ((hi_cnt == CMAX) ? hi_cnt : hi_cnt + 1'b1);
        end
    end

    p_entry_quiet_r1: assert property (@(posedge clk) disable iff (rst)
        !mode_en |-> (!pgm_clk && !pgm_dat_o && pgm_dat_oe && !req_ready));

    p_low_gap_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(pgm_clk) |-> (lo_cnt == CW'(HALF_CYC) || lo_cnt >= CW'(HALF_CYC + GAP_CYC)));

    p_high_phase_r6: assert property (@(posedge clk) disable iff (rst)
        $fell(pgm_clk) |-> (hi_cnt == CW'(HALF_CYC)));

    p_dat_steady_r6: assert property (@(posedge clk) disable iff (rst)
        $fell(pgm_clk) |-> $stable(pgm_dat_o));

    p_release_edge_r5: assert property (@(posedge clk) disable iff (rst)
        $fell(pgm_dat_oe) |-> pgm_clk);

    p_done_single_r10: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    p_ready_quiet_r10: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> (!pgm_clk && pgm_dat_oe));

    p_mode_sticky_r11: assert property (@(posedge clk) disable iff (rst)
        $past(mode_en) |-> mode_en);
endmodule

bind prog_link_host prog_link_host_chk #(.HALF_CYC(HALF_CYC), .GAP_CYC(GAP_CYC)) u_chk (.*);

// File: tb/sim_prog_link_host.sv
module sim_prog_link_host;
    localparam int HALF  = 2;
    localparam int GAP   = 12;
    localparam int PROG  = 60;
    localparam int ERASE = 150;
    localparam int PRE   = 5;
    localparam int POST  = 20;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [2:0]  req_kind = '0;
    logic [5:0]  req_cmd = '0;
    logic [13:0] req_word = '0;
    logic        done;
    logic [13:0] rd_word;
    logic        mode_en;
    logic        pgm_clk;
    logic        pgm_dat_o;
    logic        pgm_dat_oe;
    logic        pgm_dat_i = 1'b0;

    always #10 clk = ~clk;

    prog_link_host #(
        .HALF_CYC(HALF), .GAP_CYC(GAP), .PROG_CYC(PROG), .ERASE_CYC(ERASE),
        .ENTRY_PRE_CYC(PRE), .ENTRY_POST_CYC(POST)
    ) u0 (.*);

    typedef struct {
        int          len;
        logic [15:0] bits;
        bit          rd;
        int          min_gap;
        string       tag;
    } exp_t;

    exp_t        expq[$];
    int          n_checks = 0;
    int          n_fail = 0;
    int          next_gap = 0;
    logic [13:0] dev_word = '0;
    int          cyc = 0;
    bit          finished = 0;

    task automatic check(input bit ok, input string tag, input string what,
                         input longint act, input longint expv);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, expv);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    endtask

    // watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
            finish_run();
        end
    end

    // pin monitor and target model
    bit          prev_pc = 0;
    bit          in_frame = 0;
    int          idle = 1000000;
    int          hi_len = 0;
    int          gap_meas = 0;
    int          nb = 0;
    logic [15:0] fbits = '0;
    bit          rd_seen = 0;

    task automatic frame_end();
        exp_t e;
        logic [15:0] mask;
        if (expq.size() == 0) begin
            check(0, "R2", "unexpected frame", nb, 0);
            return;
        end
        e = expq.pop_front();
        mask = (e.len >= 16) ? 16'hFFFF : ((16'h1 << e.len) - 16'h1);
        check(nb == e.len, e.tag, "frame length", nb, e.len);
        check(rd_seen == e.rd, "R5", "line released", rd_seen, e.rd);
        if (!e.rd)
            check((fbits & mask) == (e.bits & mask), e.tag, "frame bits", fbits & mask, e.bits & mask);
        check(gap_meas >= e.min_gap, (e.min_gap > GAP) ? "R7" : "R4", "gap before frame",
              gap_meas, e.min_gap);
    endtask

    always @(negedge clk) begin
        if (rst) begin
            prev_pc  = 0;
            in_frame = 0;
            idle     = 1000000;
        end else begin
            if (pgm_clk && !prev_pc) begin
                if (!in_frame) begin
                    in_frame = 1;
                    gap_meas = idle;
                    nb       = 0;
                    fbits    = '0;
                    rd_seen  = 0;
                end
                hi_len = 0;
                pgm_dat_i = ({1'b0, dev_word, 1'b0} >> nb) & 16'h1;
            end
            if (pgm_clk) begin
                hi_len++;
                if (!pgm_dat_oe) rd_seen = 1;
            end
            if (!pgm_clk && prev_pc) begin
                check(hi_len == HALF, "R6", "high phase length", hi_len, HALF);
                if (nb < 16) fbits[nb] = pgm_dat_o;
                nb++;
                idle = 0;
            end else if (!pgm_clk && idle < 1000000) begin
                idle++;
            end
            if (in_frame && !pgm_clk && idle > HALF + 2) begin
                in_frame = 0;
                frame_end();
            end
            prev_pc = pgm_clk;
        end
    end

    // driver side
    task automatic push(input int len, input logic [15:0] bits, input bit rd,
                        input string tag, input int gap_after);
        exp_t e;
        e.len = len; e.bits = bits; e.rd = rd; e.min_gap = next_gap; e.tag = tag;
        expq.push_back(e);
        next_gap = gap_after;
    endtask

    function automatic int cmd_gap(input logic [5:0] c);
        return (c[3:0] == 4'b1000) ? PROG : GAP;
    endfunction

    task automatic issue(input logic [2:0] kind, input logic [5:0] cmd,
                         input logic [13:0] word);
        int n;
        @(negedge clk);
        req_valid = 1'b1; req_kind = kind; req_cmd = cmd; req_word = word;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        n = 0;
        while (!done && n < 20000) begin @(negedge clk); n++; end
        check(done, "R10", "done pulse seen", done, 1);
        @(negedge clk);
        check(!done && req_ready, "R10", "single done then ready", {done, req_ready}, 2'b01);
    endtask

    task automatic run_cmd(input logic [5:0] c, input string tag);
        push(6, {10'b0, c}, 0, tag, cmd_gap(c));
        issue(3'd0, c, 14'h1555);
    endtask

    task automatic run_write(input logic [5:0] c, input logic [13:0] w);
        push(6, {10'b0, c}, 0, "R2", GAP);
        push(16, {1'b0, w, 1'b0}, 0, "R3", GAP);
        issue(3'd1, c, w);
    endtask

    task automatic run_read(input logic [5:0] c, input logic [13:0] w);
        dev_word = w;
        push(6, {10'b0, c}, 0, "R2", GAP);
        push(16, 16'h0, 1, "R5", GAP);
        issue(3'd2, c, 14'h0);
        check(rd_word == w, "R5", "read word", rd_word, w);
    endtask

    task automatic erase_tail(input string tag);
        push(6, 16'h0001, 0, tag, GAP);
        push(6, 16'h0007, 0, tag, GAP);
        push(6, 16'h0008, 0, tag, ERASE);
        push(6, 16'h0001, 0, tag, GAP);
        push(6, 16'h0007, 0, tag, GAP);
    endtask

    initial begin
        int t;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check(!mode_en && !pgm_clk && !pgm_dat_o && pgm_dat_oe && !req_ready, "R1",
              "entry state", {mode_en, pgm_clk, pgm_dat_o, pgm_dat_oe, req_ready}, 5'b00010);
        t = 1;
        while (!mode_en && t < 1000) begin @(negedge clk); t++; end
        check(t >= PRE, "R1", "mode enable lead", t, PRE);
        t = 0;
        while (!req_ready && t < 1000) begin
            if (pgm_clk) check(0, "R1", "clock during guard", 1, 0);
            @(negedge clk); t++;
        end
        check(t >= POST, "R1", "guard after mode enable", t, POST);

        run_cmd(6'b000110, "R2");
        run_cmd(6'b100101, "R2");
        run_write(6'b000010, 14'h2A5C);
        run_write(6'b000011, 14'h3FFF);
        run_read(6'b000100, 14'h1B39);
        run_read(6'b000101, 14'h0001);
        run_read(6'b000100, 14'h2000);
        // R7 programming start then an ordinary command
        run_cmd(6'b001000, "R7");
        run_cmd(6'b000110, "R7");
        run_cmd(6'b011000, "R7");
        run_write(6'b000010, 14'h0F0F);

        // R8 unprotected erase recipe
        push(6, 16'h0002, 0, "R8", GAP);
        push(16, {1'b0, 14'h3FFF, 1'b0}, 0, "R8", GAP);
        erase_tail("R8");
        issue(3'd3, 6'h0, 14'h0);

        // R9 protected erase recipe
        push(6, 16'h0000, 0, "R9", GAP);
        push(16, {1'b0, 14'h3FFF, 1'b0}, 0, "R9", GAP);
        for (int i = 0; i < 7; i++) push(6, 16'h0006, 0, "R9", GAP);
        erase_tail("R9");
        issue(3'd4, 6'h0, 14'h0);

        // R5 rd_word unchanged by non-read requests
        check(rd_word == 14'h2000, "R5", "read word held", rd_word, 14'h2000);
        run_read(6'b000100, 14'h3FFF);

        repeat (20) @(negedge clk);
        check(expq.size() == 0, "R10", "all expected frames seen", expq.size(), 0);
        check(mode_en, "R11", "mode enable held", mode_en, 1);
        finish_run();
    end
endmodule